// File: doc/BRIEF.md
# Aliased Set/Clear/Toggle Register Bank

This block is a bank of word-wide control and status registers on a small memory-mapped request/response bus. Each register owns a 16-byte slot in the address space. The slot holds four word addresses, and the word address picks how a write changes the register:

- replace the whole value;
- OR the data in;
- clear every bit written as one;
- XOR the data in.

Software can therefore change single bits without a read-modify-write sequence and without races against other writers. A read through any of the four addresses returns the current value and changes nothing.

Both channels use a valid/ready handshake, with one response for every accepted request.

- **Requests:** a request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high.
- **Responses:** the response appears in the next cycle and stays unchanged until `rsp_ready` is high.
- **Back-pressure:** `req_ready` is high when no response is waiting or when the waiting response is taken in the same cycle. A stalled consumer therefore holds off new requests, and the bank never stores more than one response.
- **Parallel outputs:** every register value is also driven continuously on a flat output bus for the logic that the registers control.

Bits can be made read-only per register through a parameter mask. Reset values are also set by parameter.

Top module: `regalias_bank`

## Requirements
- R1: While `rst_n` is low, the registers take their reset values and `rsp_valid` is low. With the default parameters, register 1 resets to 0xA5A50000, register 7 resets to 0x12345678, and all other registers reset to zero.
- R2: A write at word offset 0x0 of a slot (address bits [3:2] = 0) replaces the register's writable bits with the write data.
- R3: A write at offset 0x4 (bits [3:2] = 1) ORs the write data into the register.
- R4: A write at offset 0x8 (bits [3:2] = 2) clears each register bit for which the write data bit is one.
- R5: A write at offset 0xC (bits [3:2] = 3) XORs the write data into the register.
- R6: Bits set in the read-only mask keep their value under all four write kinds. With the defaults, register 1 has bits [31:16] read-only, register 7 is read-only in all bits, and the others are fully writable.
- R7: Address bits [ADDR_W-1:4] choose the register and bits [3:2] choose the write kind. Bits [1:0] have no effect.
- R8: A read through any of the four offsets returns the register's current value and leaves every register unchanged.
- R9: An access to a slot index of NUM_REGS or above returns zero and changes no register. With the defaults, these are addresses 0x80 to 0xFF.
- R10: Every accepted request produces exactly one response in the following cycle. The response data is the register value after the access.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold, `req_ready` is low, and no request is accepted.
- R12: `reg_q[i*DATA_W +: DATA_W]` always shows the current value of register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address: slot index, write kind, ignored low bits |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | DATA_W | Register value after the access, or zero for an unmapped slot |
| reg_q | output | NUM_REGS*DATA_W | All register values, register 0 in the low word |

## Verification
The bench targets several corner cases where a wrong design behaves in a visible way.

- **Write kind:** a design that swaps the clear and toggle kinds, or decodes the kind from the wrong address bits, gives the wrong word on the response and on `reg_q`.
- **Read-only bits:** a design that lets the set or toggle kinds reach masked bits changes the fixed upper half of register 1 or all of register 7.
- **Unmapped slots:** a design that aliases high slot indices onto real registers returns nonzero data or corrupts a mapped register.
- **Back-pressure:** a design that ignores a stalled consumer either drops the held response or accepts a second request early, so the register takes the new value while the old response is still waiting.

// File: rtl/regalias_pkg.sv
package regalias_pkg;

  // Write kind, taken from address bits [3:2] of the access.
  typedef enum logic [1:0] {
    KIND_WRITE  = 2'd0,
    KIND_SET    = 2'd1,
    KIND_CLEAR  = 2'd2,
    KIND_TOGGLE = 2'd3
  } wr_kind_e;

  // Byte offset of the slot index inside an address.
  localparam int SLOT_LSB = 4;
  // Byte offset of the write kind inside an address.
  localparam int KIND_LSB = 2;

endpackage

// File: rtl/regalias_decode.sv
module regalias_decode
  import regalias_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 8,
  localparam int SLOT_W  = ADDR_W - SLOT_LSB
) (
  input  logic [ADDR_W-1:KIND_LSB] word_addr,
  output wr_kind_e                 kind,
  output logic [NUM_REGS-1:0]      sel,
  output logic                     hit
);

  logic [SLOT_W-1:0] slot;

  assign slot = word_addr[ADDR_W-1:SLOT_LSB];
  assign kind = wr_kind_e'(word_addr[SLOT_LSB-1:KIND_LSB]);

  // One-hot slot select. An index at or above NUM_REGS selects nothing.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel[i] = (slot == SLOT_W'(i));
  end

  assign hit = |sel;

endmodule

// File: rtl/regalias_slot.sv
module regalias_slot
  import regalias_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] RO_BITS = '0,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  wr_kind_e          kind,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] nxt,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] raw;

  always_comb begin
    unique case (kind)
      KIND_WRITE:  raw = wdata;
      KIND_SET:    raw = q | wdata;
      KIND_CLEAR:  raw = q & ~wdata;
      KIND_TOGGLE: raw = q ^ wdata;
      default:     raw = q;
    endcase
  end

  // Read-only bits keep their stored value.
  assign nxt = (q & RO_BITS) | (raw & ~RO_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (wr_en) begin
      q <= nxt;
    end
  end

endmodule

// File: rtl/regalias_rsp.sv
module regalias_rsp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] data_in,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              req_ready
);

  // Single response slot. A new request is taken only when the slot is
  // empty or is being emptied in the same cycle.
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= data_in;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/regalias_bank.sv
module regalias_bank
  import regalias_pkg::*;
#(
  parameter int                         NUM_REGS = 8,
  parameter int                         DATA_W   = 32,
  parameter int                         ADDR_W   = 8,
  parameter logic [NUM_REGS*DATA_W-1:0] RO_MASK  =
    {32'hFFFF_FFFF, {5{32'h0}}, 32'hFFFF_0000, 32'h0},
  parameter logic [NUM_REGS*DATA_W-1:0] RST_VALS =
    {32'h1234_5678, {5{32'h0}}, 32'hA5A5_0000, 32'h0}
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic [NUM_REGS*DATA_W-1:0] reg_q
);

  wr_kind_e            kind;
  logic [NUM_REGS-1:0] sel;
  logic                hit;
  logic                accept;
  logic [DATA_W-1:0]   slot_q   [NUM_REGS];
  logic [DATA_W-1:0]   slot_nxt [NUM_REGS];
  logic [DATA_W-1:0]   rsp_data;

  regalias_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
  ) u_decode (
    .word_addr (req_addr[ADDR_W-1:KIND_LSB]),
    .kind      (kind),
    .sel       (sel),
    .hit       (hit)
  );

  assign accept = req_valid && req_ready;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    regalias_slot #(
      .DATA_W  (DATA_W),
      .RO_BITS (RO_MASK[i*DATA_W +: DATA_W]),
      .RST_VAL (RST_VALS[i*DATA_W +: DATA_W])
    ) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (accept && req_write && sel[i]),
      .kind  (kind),
      .wdata (req_wdata),
      .nxt   (slot_nxt[i]),
      .q     (slot_q[i])
    );
    assign reg_q[i*DATA_W +: DATA_W] = slot_q[i];
  end

  // Response word: the value the register holds after this access.
  // An unmapped slot index gives zero.
  always_comb begin
    rsp_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel[i]) begin
        rsp_data = req_write ? slot_nxt[i] : slot_q[i];
      end
    end
    if (!hit) begin
      rsp_data = '0;
    end
  end

  regalias_rsp #(
    .DATA_W (DATA_W)
  ) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .data_in   (rsp_data),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .req_ready (req_ready)
  );

endmodule

// File: rtl/regalias_checker.sv
module regalias_checker #(
  parameter int                         NUM_REGS = 8,
  parameter int                         DATA_W   = 32,
  parameter int                         SLOT_W   = 4,
  parameter logic [NUM_REGS*DATA_W-1:0] RO_MASK  = '0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic                       req_write,
  input logic [SLOT_W-1:0]          slot_idx,
  input logic                       rsp_valid,
  input logic                       rsp_ready,
  input logic [DATA_W-1:0]          rsp_rdata,
  input logic [NUM_REGS*DATA_W-1:0] reg_q
);

  logic taken;
  logic unmapped;

  assign taken    = req_valid && req_ready;
  assign unmapped = (int'(slot_idx) >= NUM_REGS);

  // R6: masked bits never move.
  p_ro_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(reg_q & RO_MASK));

  // R8: a read leaves every register unchanged.
  p_read_pure_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !req_write) |=> $stable(reg_q));

  // R9: an unmapped access changes nothing.
  p_unmapped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && unmapped) |=> $stable(reg_q));

  // R9: an unmapped access returns zero.
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && unmapped) |=> (rsp_rdata == '0));

  // R10: each accepted request yields a response next cycle.
  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> rsp_valid);

  // R10: no request and a taken response leave the channel empty.
  p_rsp_drains_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!taken && rsp_valid && rsp_ready) |=> !rsp_valid);

  // R11: a stalled response holds its valid and data.
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R11: no register moves while stalled.
  p_stall_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> $stable(reg_q));

endmodule

bind regalias_bank regalias_checker #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .SLOT_W   (ADDR_W - 4),
  .RO_MASK  (RO_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .slot_idx  (req_addr[ADDR_W-1:4]),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .reg_q     (reg_q)
);

// File: tb/regalias_bank_bench.sv
module regalias_bank_bench;

  localparam int NR = 8;
  localparam int DW = 32;
  localparam int AW = 8;

  // Defaults stated in R1 and R6.
  localparam logic [31:0] RO_M  [NR] = '{32'h0, 32'hFFFF_0000, 32'h0, 32'h0,
                                         32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF};
  localparam logic [31:0] RST_M [NR] = '{32'h0, 32'hA5A5_0000, 32'h0, 32'h0,
                                         32'h0, 32'h0, 32'h0, 32'h1234_5678};

  // Vector fields: {write, addr[7:0], wdata[31:0], expected rdata[31:0]}.
  localparam int NV = 17;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R2 plain write
    {1'b1, 8'h04, 32'h0000_0100, 32'hDEAD_BFEF},  // R3 set
    {1'b1, 8'h08, 32'hFF00_0000, 32'h00AD_BFEF},  // R4 clear
    {1'b1, 8'h0C, 32'h0000_FFFF, 32'h00AD_4010},  // R5 toggle
    {1'b0, 8'h08, 32'hFFFF_FFFF, 32'h00AD_4010},  // R8 read via clear offset
    {1'b0, 8'h03, 32'h0000_0000, 32'h00AD_4010},  // R7 low bits ignored
    {1'b1, 8'h10, 32'hFFFF_FFFF, 32'hA5A5_FFFF},  // R6 plain, upper fixed
    {1'b1, 8'h18, 32'hFFFF_FFFF, 32'hA5A5_0000},  // R6 clear
    {1'b1, 8'h1C, 32'hFFFF_1234, 32'hA5A5_1234},  // R6 toggle
    {1'b1, 8'h14, 32'h5A5A_0001, 32'hA5A5_1235},  // R6 set
    {1'b1, 8'h70, 32'h0000_0000, 32'h1234_5678},  // R6 fully fixed
    {1'b1, 8'h7C, 32'hFFFF_FFFF, 32'h1234_5678},  // R6 fully fixed toggle
    {1'b1, 8'h80, 32'hFFFF_FFFF, 32'h0000_0000},  // R9 unmapped write
    {1'b0, 8'hF4, 32'h0000_0000, 32'h0000_0000},  // R9 unmapped read
    {1'b0, 8'h10, 32'h0000_0000, 32'hA5A5_1235},  // R8 read plain offset
    {1'b1, 8'h2E, 32'h0F0F_0000, 32'h0F0F_0000},  // R7 toggle, low bits 2
    {1'b1, 8'h25, 32'h0000_00F0, 32'h0F0F_00F0}   // R7 set, low bits 1
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [DW-1:0]     req_wdata = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic [DW-1:0]     rsp_rdata;
  logic [NR*DW-1:0]  reg_q;

  int          nchk  = 0;
  int          nfail = 0;
  logic [31:0] mdl [NR];

  always #10 clk = ~clk;

  regalias_bank u_regalias_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .reg_q     (reg_q)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  // Reference model: returns the expected response and updates the registers.
  function automatic logic [31:0] model(input logic w, input logic [7:0] a,
                                        input logic [31:0] d);
    int unsigned idx = a[7:4];
    logic [31:0] cur, raw, nv;
    if (idx >= NR) return 32'h0;
    cur = mdl[idx];
    if (!w) return cur;
    case (a[3:2])
      2'd0:    raw = d;
      2'd1:    raw = cur | d;
      2'd2:    raw = cur & ~d;
      default: raw = cur ^ d;
    endcase
    nv = (cur & RO_M[idx]) | (raw & ~RO_M[idx]);
    mdl[idx] = nv;
    return nv;
  endfunction

  task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] got, output logic [31:0] exp);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    exp = model(w, a, d);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1, "R10 rsp_valid", {31'b0, rsp_valid}, 32'h1);
    got = rsp_rdata;
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NR; i++) begin
      check(reg_q[i*DW +: DW] === mdl[i], req, reg_q[i*DW +: DW], mdl[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [31:0] got, exp;
    for (int i = 0; i < NR; i++) mdl[i] = RST_M[i];

    // R1: reset state.
    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b0, "R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
    check_regs("R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1, "R11 req_ready idle", {31'b0, req_ready}, 32'h1);

    // Table of vectors.
    for (int v = 0; v < NV; v++) begin
      access(VEC[v][72], VEC[v][71:64], VEC[v][63:32], got, exp);
      check(got === VEC[v][31:0], "R2-table vector", got, VEC[v][31:0]);
      check(exp === VEC[v][31:0], "model vs table", exp, VEC[v][31:0]);
    end
    // R12: parallel outputs after the table.
    check_regs("R12 parallel outputs");
    @(negedge clk);
    check(rsp_valid === 1'b0, "R10 single response", {31'b0, rsp_valid}, 32'h0);

    // R11: back-pressure.
    rsp_ready = 1'b0;
    access(1'b1, 8'h30, 32'h1111_1111, got, exp);
    check(got === exp, "R11 stalled data", got, exp);
    check(req_ready === 1'b0, "R11 req_ready low", {31'b0, req_ready}, 32'h0);
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = 8'h30;
    req_wdata = 32'h2222_2222;
    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b1, "R11 valid held", {31'b0, rsp_valid}, 32'h1);
    check(rsp_rdata === 32'h1111_1111, "R11 data held", rsp_rdata, 32'h1111_1111);
    check(reg_q[3*DW +: DW] === 32'h1111_1111, "R11 no accept",
          reg_q[3*DW +: DW], 32'h1111_1111);
    rsp_ready = 1'b1;
    exp = model(1'b1, 8'h30, 32'h2222_2222);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_rdata === exp, "R11 accept after release", rsp_rdata, exp);
    check(reg_q[3*DW +: DW] === exp, "R11 register after release",
          reg_q[3*DW +: DW], exp);

    // Random sequences against the model.
    for (int n = 0; n < 400; n++) begin
      logic        w = ($urandom_range(0, 3) != 0);
      logic [7:0]  a = 8'($urandom_range(0, 255));
      logic [31:0] d = $urandom;
      access(w, a, d, got, exp);
      check(got === exp, "R3 R4 R5 random response", got, exp);
      check_regs("R12 random registers");
    end

    // R1: a second reset restores defaults.
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < NR; i++) mdl[i] = RST_M[i];
    @(negedge clk);
    check_regs("R1 re-reset");
    check(rsp_valid === 1'b0, "R1 rsp_valid re-reset", {31'b0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    report();
    $finish;
  end

endmodule